// File: doc/BRIEF.md
# AXI Read Width Upsizer

This block sits on the read path between a 64-bit AXI initiator and a 256-bit AXI target. The target does not honour narrow transfer sizes on reads. Whatever size it is asked for, it returns full 32-byte beats packed with consecutive memory, sometimes followed by spare beats. AXI read data carries no byte strobe. The adapter therefore rewrites every narrow read request into a full-width request, and it keeps its own record of where each narrow beat lives inside the returned wide data.

On the address side, each narrow INCR request passes straight through with a new address, size and length. At the same moment, the start offset, size and beat count of the request are pushed into a small in-order table. On the data side, the adapter walks a running address through the burst. For every narrow beat it picks the 8-byte lane of the current wide beat that this address selects. It moves on to the next wide beat only when the running address enters a new 32-byte block. Once the narrow burst has finished, any spare wide beats are swallowed until the target's own last beat.

Top module: `axi_rd_upsizer`

## Requirements
- R1: After reset, the block presents no read data (`s_rvalid`=0), issues no wide request (`m_arvalid`=0) and is ready to accept a request (`s_arready`=1 while `m_arready`=1).
- R2: The forwarded wide request has an address equal to the narrow address rounded down to a multiple of 32. It also carries size code 5 and burst code 2'b01 (INCR). Narrow requests use size codes 0 to 3 only.
- R3: The forwarded length field equals floor(E/32) − floor(A/32). Here A is the narrow address, N is the narrow beat count (arlen+1), S is 2^size, and E = (A rounded down to S) + N·S − 1.
- R4: Exactly N narrow beats are returned per request. Beat 0 has running address A, and beat i>0 has (A rounded down to S) + i·S. The data of each beat is the 64-bit lane selected by bits [4:3] of its running address, so it equals memory bytes at (address rounded down to 8) through +7.
- R5: A wide beat is consumed only when the running address of the next narrow beat falls in a different 32-byte block, or when the current narrow beat is the last one. Narrow beats that share a 32-byte block are taken from the same wide beat.
- R6: `s_rlast` is high on the N-th narrow beat of each request and low on all others.
- R7: Every narrow beat carries the response code of the wide beat it was taken from.
- R8: Wide beats that arrive after the final narrow beat, up to and including the target's last beat, are accepted and discarded. They never appear on the narrow side and do not disturb the following request.
- R9: Up to 4 requests may be outstanding. With 4 outstanding, `s_arready` and `m_arvalid` stay low.
- R10: Once `s_rvalid` is asserted without `s_rready`, it stays high with unchanged data until the transfer completes. A forwarded request likewise holds until accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_arvalid | input | 1 | Narrow request valid |
| s_arready | output | 1 | Narrow request ready |
| s_araddr | input | AW | Narrow request byte address |
| s_arlen | input | 8 | Narrow beat count minus one |
| s_arsize | input | 3 | Narrow beat size code (0..3) |
| s_rvalid | output | 1 | Narrow read data valid |
| s_rready | input | 1 | Narrow read data ready |
| s_rdata | output | NDW | Narrow read data |
| s_rresp | output | 2 | Narrow read response |
| s_rlast | output | 1 | Final narrow beat of a burst |
| m_arvalid | output | 1 | Wide request valid |
| m_arready | input | 1 | Wide request ready |
| m_araddr | output | AW | Wide request address, 32-byte aligned |
| m_arlen | output | 8 | Wide beat count minus one |
| m_arsize | output | 3 | Wide beat size code |
| m_arburst | output | 2 | Wide burst type (INCR) |
| m_rvalid | input | 1 | Wide read data valid |
| m_rready | output | 1 | Wide read data ready |
| m_rdata | input | WDW | Wide read data |
| m_rresp | input | 2 | Wide read response |
| m_rlast | input | 1 | Target's final wide beat |

## Verification
The bench uses the default widths (64 narrow, 256 wide, four lanes) and the table depth of 4. With a depth this shallow, a fifth request run against a stalled target reaches the full-table stall in a few cycles. The four-lane split makes it possible to hit starting offsets in every lane, runs that wrap from lane 3 into a new wide beat, and single-byte beats that stay many cycles on one wide beat. The bench's target model can append spare beats and insert random idle cycles. Together with random ready patterns, this covers the discard of spare beats and the hold rules under backpressure.

// File: rtl/axi_up_pkg.sv
package axi_up_pkg;

  localparam int OFS_W = 12;

  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    logic [2:0]       size;
    logic [7:0]       len;
  } up_req_t;

  function automatic logic [OFS_W-1:0] size_floor(input logic [OFS_W-1:0] a,
                                                  input logic [2:0] sz);
    return a & ~((OFS_W'(1) << sz) - OFS_W'(1));
  endfunction

  function automatic logic [OFS_W-1:0] step_addr(input logic [OFS_W-1:0] a,
                                                 input logic [2:0] sz);
    return size_floor(a, sz) + (OFS_W'(1) << sz);
  endfunction

  function automatic logic [7:0] wide_len_m1(input logic [OFS_W-1:0] a,
                                             input logic [7:0] len,
                                             input logic [2:0] sz,
                                             input int wshift);
    logic [OFS_W:0] span;
    logic [OFS_W:0] last_b;
    span   = ((OFS_W+1)'(len) + (OFS_W+1)'(1)) << sz;
    last_b = {1'b0, size_floor(a, sz)} + span - (OFS_W+1)'(1);
    return 8'((last_b >> wshift) - ({1'b0, a} >> wshift));
  endfunction

  function automatic logic same_block(input logic [OFS_W-1:0] a,
                                      input logic [OFS_W-1:0] b,
                                      input int wshift);
    return (a >> wshift) == (b >> wshift);
  endfunction

endpackage

// File: rtl/up_req_fifo.sv
module up_req_fifo #(
  parameter int W     = 23,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4

endmodule

// File: rtl/up_ar_xlate.sv
module up_ar_xlate
  import axi_up_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NSHIFT = 3,
  parameter int WSHIFT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_arvalid,
  output logic          s_arready,
  input  logic [AW-1:0] s_araddr,
  input  logic [7:0]    s_arlen,
  input  logic [2:0]    s_arsize,
  output logic          m_arvalid,
  input  logic          m_arready,
  output logic [AW-1:0] m_araddr,
  output logic [7:0]    m_arlen,
  output logic [2:0]    m_arsize,
  output logic [1:0]    m_arburst,
  input  logic          tbl_full,
  output logic          req_push,
  output up_req_t       req_data
);

  assign m_arvalid = s_arvalid & ~tbl_full;
  assign s_arready = m_arready & ~tbl_full;
  assign m_araddr  = {s_araddr[AW-1:WSHIFT], {WSHIFT{1'b0}}};
  assign m_arlen   = wide_len_m1(s_araddr[OFS_W-1:0], s_arlen, s_arsize, WSHIFT);
  assign m_arsize  = 3'(WSHIFT);
  assign m_arburst = 2'b01;
  assign req_push  = m_arvalid & m_arready;
  assign req_data  = '{ofs: s_araddr[OFS_W-1:0], size: s_arsize, len: s_arlen};

  AST_NARROW_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid |-> (s_arsize <= 3'(NSHIFT))); // R2
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> m_arvalid); // R10

endmodule

// File: rtl/up_r_unpack.sv
module up_r_unpack
  import axi_up_pkg::*;
#(
  parameter int NDW = 64,
  parameter int WDW = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  up_req_t        head,
  input  logic           head_valid,
  output logic           head_pop,
  input  logic           m_rvalid,
  output logic           m_rready,
  input  logic [WDW-1:0] m_rdata,
  input  logic [1:0]     m_rresp,
  input  logic           m_rlast,
  output logic           s_rvalid,
  input  logic           s_rready,
  output logic [NDW-1:0] s_rdata,
  output logic [1:0]     s_rresp,
  output logic           s_rlast
);
  localparam int LANES  = WDW / NDW;
  localparam int NSHIFT = $clog2(NDW / 8);
  localparam int WSHIFT = $clog2(WDW / 8);

  logic             mid, drain;
  logic [OFS_W-1:0] run_addr;
  logic [7:0]       run_cnt;

  logic [OFS_W-1:0] cur_addr, nxt_addr;
  logic [7:0]       cur_cnt;
  logic             narrow_last, block_change, beat_go, wide_take;
  logic [NDW-1:0]   lane_data [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_data[g] = m_rdata[g*NDW +: NDW];
    end
  endgenerate

  assign cur_addr     = mid ? run_addr : head.ofs;
  assign cur_cnt      = mid ? run_cnt  : 8'd0;
  assign nxt_addr     = step_addr(cur_addr, head.size);
  assign narrow_last  = (cur_cnt == head.len);
  assign block_change = ~same_block(cur_addr, nxt_addr, WSHIFT);

  assign s_rvalid  = m_rvalid & head_valid & ~drain;
  assign s_rdata   = lane_data[cur_addr[WSHIFT-1:NSHIFT]];
  assign s_rresp   = m_rresp;
  assign s_rlast   = narrow_last;
  assign m_rready  = drain | (head_valid & s_rready & (block_change | narrow_last));
  assign beat_go   = s_rvalid & s_rready;
  assign wide_take = m_rvalid & m_rready;
  assign head_pop  = beat_go & narrow_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid      <= 1'b0;
      drain    <= 1'b0;
      run_addr <= '0;
      run_cnt  <= '0;
    end else begin
      if (beat_go) begin
        if (narrow_last) begin
          mid   <= 1'b0;
          drain <= ~m_rlast;
        end else begin
          mid      <= 1'b1;
          run_addr <= nxt_addr;
          run_cnt  <= cur_cnt + 8'd1;
        end
      end
      if (drain && wide_take && m_rlast) drain <= 1'b0;
    end
  end

  AST_WIDE_LAST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_take && m_rlast && !drain) |-> (beat_go && s_rlast)); // R6
  AST_SVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R10
  AST_NO_ORPHAN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> (head_valid || drain)); // R8
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mid |-> (head_valid && run_cnt <= head.len)); // R4

endmodule

// File: rtl/axi_rd_upsizer.sv
module axi_rd_upsizer
  import axi_up_pkg::*;
#(
  parameter int AW        = 32,
  parameter int NDW       = 64,
  parameter int WDW       = 256,
  parameter int TBL_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_arvalid,
  output logic           s_arready,
  input  logic [AW-1:0]  s_araddr,
  input  logic [7:0]     s_arlen,
  input  logic [2:0]     s_arsize,
  output logic           s_rvalid,
  input  logic           s_rready,
  output logic [NDW-1:0] s_rdata,
  output logic [1:0]     s_rresp,
  output logic           s_rlast,
  output logic           m_arvalid,
  input  logic           m_arready,
  output logic [AW-1:0]  m_araddr,
  output logic [7:0]     m_arlen,
  output logic [2:0]     m_arsize,
  output logic [1:0]     m_arburst,
  input  logic           m_rvalid,
  output logic           m_rready,
  input  logic [WDW-1:0] m_rdata,
  input  logic [1:0]     m_rresp,
  input  logic           m_rlast
);
  localparam int NSHIFT = $clog2(NDW / 8);
  localparam int WSHIFT = $clog2(WDW / 8);
  localparam int REQ_W  = $bits(up_req_t);

  logic    tbl_full, tbl_empty, req_push, head_pop;
  up_req_t req_data, head;

  up_ar_xlate #(.AW(AW), .NSHIFT(NSHIFT), .WSHIFT(WSHIFT)) u_ar (
    .clk(clk), .rst_n(rst_n),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_arlen(s_arlen), .s_arsize(s_arsize),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .tbl_full(tbl_full), .req_push(req_push), .req_data(req_data)
  );

  up_req_fifo #(.W(REQ_W), .DEPTH(TBL_DEPTH)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .push(req_push), .din(req_data), .full(tbl_full),
    .pop(head_pop), .dout(head), .empty(tbl_empty)
  );

  up_r_unpack #(.NDW(NDW), .WDW(WDW)) u_r (
    .clk(clk), .rst_n(rst_n),
    .head(head), .head_valid(~tbl_empty), .head_pop(head_pop),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
    .m_rresp(m_rresp), .m_rlast(m_rlast),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .s_rlast(s_rlast)
  );

  AST_FULL_BLOCKS_AR: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full |-> (!s_arready && !m_arvalid)); // R9

endmodule

// File: tb/tb_axi_rd_upsizer.sv
`timescale 1ns/1ps
module tb_axi_rd_upsizer;
  localparam int AW = 32, NDW = 64, WDW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_arvalid = 0, s_arready, s_rvalid, s_rready = 0, s_rlast;
  logic [AW-1:0] s_araddr = '0;
  logic [7:0] s_arlen = '0;
  logic [2:0] s_arsize = '0;
  logic [NDW-1:0] s_rdata;
  logic [1:0] s_rresp;
  logic m_arvalid, m_arready = 1, m_rvalid = 0, m_rready, m_rlast = 0;
  logic [AW-1:0] m_araddr;
  logic [7:0] m_arlen;
  logic [2:0] m_arsize;
  logic [1:0] m_arburst, m_rresp = '0;
  logic [WDW-1:0] m_rdata = '0;

  always #5 clk = ~clk;

  axi_rd_upsizer dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R4";

  int unsigned pa[$], pl[$], ps[$];
  logic [NDW-1:0] ex_data[$];
  bit ex_last[$];
  logic [1:0] ex_resp[$];
  int unsigned ea_addr[$], ea_len[$], tq_addr[$], tq_len[$];
  bit t_act = 0, r_took = 0, a_took = 0;
  int unsigned t_addr, t_len, t_beat, t_extra;
  int surplus = 0, ar_acc = 0;
  bit gap_en = 0, bp_en = 0, arbp_en = 0, hold_r = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 0;
  logic [NDW-1:0] prev_d;

  function automatic logic [7:0] mem_b(input int unsigned a);
    return 8'(a * 13 + (a >> 7) + 5);
  endfunction
  function automatic logic [NDW-1:0] narrow_word(input int unsigned a);
    logic [NDW-1:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = mem_b((a / 8) * 8 + i);
    return w;
  endfunction
  function automatic logic [WDW-1:0] wide_word(input int unsigned blk);
    logic [WDW-1:0] w;
    for (int i = 0; i < 32; i++) w[8*i +: 8] = mem_b(blk + i);
    return w;
  endfunction
  function automatic logic [1:0] resp_of(input int unsigned a);
    return (((a / 32) % 4) == 3) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (a_took) begin
      s_arvalid = 0; a_took = 0;
      void'(pa.pop_front()); void'(pl.pop_front()); void'(ps.pop_front());
    end
    if (!s_arvalid && pa.size() > 0) begin
      s_arvalid = 1; s_araddr = pa[0]; s_arlen = 8'(pl[0]); s_arsize = 3'(ps[0]);
    end
    if (r_took) begin m_rvalid = 0; r_took = 0; end
    if (!t_act && tq_addr.size() > 0) begin
      t_act = 1; t_addr = tq_addr.pop_front(); t_len = tq_len.pop_front();
      t_beat = 0; t_extra = surplus;
    end
    if (!m_rvalid && t_act && !hold_r && (!gap_en || lfsr[0])) begin
      m_rvalid = 1;
      if (t_beat <= t_len) begin
        m_rdata = wide_word(t_addr + 32 * t_beat);
        m_rresp = resp_of(t_addr + 32 * t_beat);
      end else begin
        m_rdata = {8{32'hBAD0F00D}};
        m_rresp = 2'b11;
      end
      m_rlast = (t_beat == t_len + t_extra);
    end
    s_rready  = bp_en ? lfsr[2] : 1'b1;
    m_arready = arbp_en ? lfsr[3] : 1'b1;
  endtask

  task automatic sample();
    if (prev_stall)
      chk(s_rvalid && s_rdata == prev_d, "R10", {191'd0, s_rvalid, s_rdata}, {191'd1, prev_d});
    prev_stall = s_rvalid && !s_rready;
    prev_d = s_rdata;
    if (s_arvalid && s_arready) begin
      int unsigned a, nb, n, base, ai;
      a = s_araddr; nb = 1 << s_arsize; n = s_arlen + 1; base = a - (a % nb);
      for (int i = 0; i < int'(n); i++) begin
        ai = (i == 0) ? a : base + i * nb;
        ex_data.push_back(narrow_word(ai));
        ex_last.push_back(i == int'(n) - 1);
        ex_resp.push_back(resp_of(ai));
      end
      ea_addr.push_back(a - (a % 32));
      ea_len.push_back((base + n * nb - 1) / 32 - a / 32);
      a_took = 1; ar_acc++;
    end
    if (m_arvalid && m_arready) begin
      if (ea_addr.size() == 0) chk(0, "R2", 256'(m_araddr), 0);
      else begin
        int unsigned xa, xl;
        xa = ea_addr.pop_front(); xl = ea_len.pop_front();
        chk(m_araddr == xa && m_arsize == 3'd5 && m_arburst == 2'b01, "R2",
            {m_araddr, m_arsize, m_arburst}, {xa, 3'd5, 2'b01});
        chk(m_arlen == 8'(xl), "R3", 256'(m_arlen), 256'(xl));
        tq_addr.push_back(xa); tq_len.push_back(xl);
      end
    end
    if (s_rvalid && s_rready) begin
      if (ex_data.size() == 0) chk(0, "R4", 256'(s_rdata), 0);
      else begin
        logic [NDW-1:0] xd; bit xlst; logic [1:0] xr;
        xd = ex_data.pop_front(); xlst = ex_last.pop_front(); xr = ex_resp.pop_front();
        chk(s_rdata == xd, {cur_tag, " R4/R5 data"}, 256'(s_rdata), 256'(xd));
        chk(s_rlast == xlst, "R6", 256'(s_rlast), 256'(xlst));
        chk(s_rresp == xr, "R7", 256'(s_rresp), 256'(xr));
      end
    end
    if (m_rvalid && m_rready) begin
      r_took = 1;
      if (t_beat == t_len + t_extra) t_act = 0; else t_beat++;
    end
  endtask

  task automatic step();
    @(posedge clk); #1; drive(); #4; sample();
  endtask

  task automatic req(input int unsigned a, input int unsigned l, input int unsigned s);
    pa.push_back(a); pl.push_back(l); ps.push_back(s);
  endtask

  task automatic run_idle();
    bit idle = 0;
    for (int k = 0; k < 6000 && !idle; k++) begin
      step();
      idle = (pa.size() == 0) && (ex_data.size() == 0) && (tq_addr.size() == 0) &&
             !t_act && !m_rvalid && !s_arvalid;
    end
    chk(idle, {cur_tag, " idle"}, 256'(ex_data.size()), 0);
    repeat (3) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #5;
    chk(!s_rvalid && !m_arvalid && !m_rready, "R1", {s_rvalid, m_arvalid, m_rready}, 0);
    @(posedge clk); #1 rst_n = 1; #4;
    chk(s_arready && !s_rvalid, "R1", {s_arready, s_rvalid}, 2'b10);

    cur_tag = "R4";
    req(32'h100, 0, 3); req(32'h100, 3, 3); req(32'h1008, 7, 3);
    req(32'h2000, 15, 3); req(32'h0010_0000, 3, 3);
    run_idle();

    cur_tag = "R5";
    req(32'h3014, 9, 2); req(32'h401f, 20, 1); req(32'h503d, 40, 0);
    req(32'h601c, 5, 3); req(32'h605f, 70, 0); req(32'h6ffe, 2, 2);
    run_idle();

    cur_tag = "R8"; surplus = 2;
    req(32'h8000, 1, 3); req(32'h8104, 3, 2); req(32'h8240, 0, 0);
    run_idle();
    surplus = 0;

    cur_tag = "R10"; gap_en = 1; bp_en = 1; arbp_en = 1;
    for (int k = 0; k < 12; k++) req(32'h9000 + k * 32'h53, (k * 7) % 19, k % 4);
    surplus = 1;
    for (int k = 0; k < 4; k++) req(32'hA100 + k * 32'h2B, k + 2, (k + 1) % 4);
    run_idle();
    surplus = 0; gap_en = 0; bp_en = 0; arbp_en = 0;

    cur_tag = "R9"; hold_r = 1;
    begin
      int base_acc;
      base_acc = ar_acc;
      for (int k = 0; k < 5; k++) req(32'hB000 + k * 64, 2, 3);
      repeat (20) step();
      chk(ar_acc - base_acc == 4, "R9", 256'(ar_acc - base_acc), 4);
      chk(s_arvalid && !s_arready && !m_arvalid, "R9", {s_arvalid, s_arready, m_arvalid}, 3'b100);
    end
    hold_r = 0;
    run_idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule